// File: doc/BRIEF.md
# Power-On Self-Test Sequencer

This block runs a built-in self-test each time the device leaves reset and reports the outcome in a 32-bit result register. It watches an active-high device reset input and a busy input. When the device reset falls while busy is low, the block starts the test. It steps through a parameterised internal control-ROM table and compresses each word into a 32-bit signature. At the end it stores the signature XORed with an expected value, so zero means pass and any other value identifies a fault. It then raises a one-cycle internal reset pulse and goes into normal operation, which it shows with a ready flag.

When busy is high at the falling edge, the test is skipped. The result is cleared to zero and normal operation begins at once. Raising the device reset again in any state abandons whatever is in progress and returns the block to idle. The length of the run is a parameter. It defaults to 2^19 cycles and can be made much shorter for simulation.

Top module: `selftest_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `test_active`, `int_reset_pulse` and `ready` are 0 after that edge and `result` is 0. The block powers up treating the device reset as already high.
- R2: A test starts only in the cycle where `dev_reset` is first seen low after being high and `busy_in` is low in that same cycle. `test_active` goes to 1 after the next clock edge.
- R3: If `busy_in` is high in the cycle where `dev_reset` falls, no test runs. After the next edge `ready` is 1 and `result` is 0.
- R4: A test holds `test_active` high for exactly `TEST_CYCLES`+1 consecutive cycles: `TEST_CYCLES` ROM steps followed by one compare cycle.
- R5: Step k (k from 0) reads ROM address k mod `ROM_DEPTH`. `ROM_DEPTH` is a power of two and `TEST_CYCLES` ≥ `ROM_DEPTH`, so every entry is read. The word at address a is (a × 0x9E3779B1 mod 2^32) XOR `ROM_SEED`.
- R6: The signature starts at `SIG_SEED`. Each step maps S to (S shifted left by one) XOR (`SIG_POLY` if bit 31 of S was 1) XOR word.
- R7: In the compare cycle, `result` is loaded with signature XOR `EXPECTED_SIG`. It then holds until the next test completes, the next skip, or `rst_n`.
- R8: After the compare cycle, `int_reset_pulse` is high for exactly one cycle. `ready` is 1 in the following cycle.
- R9: `dev_reset` high at any clock edge returns the block to idle: `test_active`, `int_reset_pulse` and `ready` are 0 after that edge, and `result` is unchanged.
- R10: With `dev_reset` held high no test starts. With `dev_reset` held low in normal operation, `ready` stays 1 and `result` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the sequencer |
| dev_reset | input | 1 | Device reset, active high; its falling edge arms the test |
| busy_in | input | 1 | When high at the falling edge, the self-test is skipped |
| test_active | output | 1 | High while ROM steps and the compare run |
| int_reset_pulse | output | 1 | One-cycle internal reset at the end of a test |
| ready | output | 1 | High in normal operation |
| result | output | 32 | Signature XOR expected; zero means pass |

## Verification
The assertions check on every cycle that the three phase flags are never high together, that the reset pulse lasts a single cycle and is followed by ready, that a high device reset empties every phase, and that a start happens only after a low-reset, low-busy cycle. They also check that ready persists and the result is frozen while the device reset stays low. Only the bench's scenarios can show that the run lasts exactly the configured number of steps and that the stored value matches a signature computed independently from the ROM formula and polynomial. The bench also shows that a mismatched expected value yields the right nonzero code, that the skip path clears an earlier failure code, and that an aborted run leaves the result untouched.

// File: rtl/selftest_pkg.sv
// Package: shared types and pure functions for the self-test sequencer.
// Assumes 32-bit ROM words and a 32-bit signature register.
package selftest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_CHECK = 3'd2,
        ST_PULSE = 3'd3,
        ST_NORM  = 3'd4
    } seq_state_t;

    // Contents of one ROM entry, computed from its address and a seed.
    function automatic logic [31:0] rom_word(input logic [31:0] addr,
                                             input logic [31:0] seed);
        rom_word = (addr * 32'h9E37_79B1) ^ seed;
    endfunction

    // One compression step of the multiple-input signature register.
    function automatic logic [31:0] misr_next(input logic [31:0] sig,
                                              input logic [31:0] din,
                                              input logic [31:0] poly);
        misr_next = {sig[30:0], 1'b0} ^ (sig[31] ? poly : 32'h0) ^ din;
    endfunction

endpackage

// File: rtl/selftest_rom.sv
// Module: read-only table of control words, built at elaboration.
// Assumes DEPTH is a power of two of at least 2; the read is combinational.
module selftest_rom
    import selftest_pkg::*;
#(
    parameter int          DEPTH = 256,
    parameter logic [31:0] SEED  = 32'hC3A5_0F1E,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output logic [31:0]   word
);

    logic [31:0] table_q [DEPTH];

    // Fill every entry from the address-based content formula.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = rom_word(32'(i), SEED);
    end

    // Select the addressed entry.
    assign word = table_q[addr];

endmodule

// File: rtl/selftest_misr.sv
// Module: 32-bit multiple-input signature register.
// Assumes load and shift are never high together; load has priority.
module selftest_misr
    import selftest_pkg::*;
#(
    parameter logic [31:0] POLY = 32'h04C1_1DB7,
    parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        shift,
    input  logic [31:0] din,
    output logic [31:0] sig
);

    // Seed on load, compress one word on shift, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      sig <= INIT;
        else if (load)   sig <= INIT;
        else if (shift)  sig <= misr_next(sig, din, POLY);
    end

endmodule

// File: rtl/selftest_ctrl.sv
// Module: phase controller, with device-reset edge detection and a step counter.
// Assumes dev_reset and busy_in are synchronous to clk.
module selftest_ctrl
    import selftest_pkg::*;
#(
    parameter int TEST_CYCLES = 524288,
    parameter int ROM_DEPTH   = 256,
    localparam int AW = $clog2(ROM_DEPTH),
    localparam int CW = $clog2(TEST_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dev_reset,
    input  logic          busy_in,
    output seq_state_t    state,
    output logic [AW-1:0] rom_addr,
    output logic          misr_load,
    output logic          misr_shift,
    output logic          res_capture,
    output logic          res_clear
);

    localparam logic [CW-1:0] LAST_STEP = CW'(TEST_CYCLES - 1);

    logic          dev_reset_q;
    logic [CW-1:0] step_q;
    logic          fall;
    seq_state_t    state_d;

    // Remember the previous device-reset level; power-up assumes it was high.
    always_ff @(posedge clk) begin
        if (!rst_n) dev_reset_q <= 1'b1;
        else        dev_reset_q <= dev_reset;
    end

    assign fall = dev_reset_q & ~dev_reset;

    // Next-phase decision; a high device reset overrides everything.
    always_comb begin
        state_d = state;
        if (dev_reset) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (fall) state_d = busy_in ? ST_NORM : ST_RUN;
                ST_RUN:   if (step_q == LAST_STEP) state_d = ST_CHECK;
                ST_CHECK: state_d = ST_PULSE;
                ST_PULSE: state_d = ST_NORM;
                ST_NORM:  state_d = ST_NORM;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Step counter: cleared at the start of a run, advanced once per ROM step.
    always_ff @(posedge clk) begin
        if (!rst_n)                 step_q <= '0;
        else if (state != ST_RUN)   step_q <= '0;
        else                        step_q <= step_q + 1'b1;
    end

    // Wrap the step count onto the ROM address space.
    assign rom_addr    = step_q[AW-1:0];
    assign misr_load   = (state == ST_IDLE) & fall & ~busy_in & ~dev_reset;
    assign misr_shift  = (state == ST_RUN) & ~dev_reset;
    assign res_capture = (state == ST_CHECK) & ~dev_reset;
    assign res_clear   = (state == ST_IDLE) & fall & busy_in & ~dev_reset;

endmodule

// File: rtl/selftest_seq.sv
// Module: top of the power-on self-test sequencer.
// Assumes ROM_DEPTH is a power of two of at least 2 and TEST_CYCLES >= ROM_DEPTH.
module selftest_seq
    import selftest_pkg::*;
#(
    parameter int          TEST_CYCLES  = 524288,
    parameter int          ROM_DEPTH    = 256,
    parameter logic [31:0] ROM_SEED     = 32'hC3A5_0F1E,
    parameter logic [31:0] SIG_POLY     = 32'h04C1_1DB7,
    parameter logic [31:0] SIG_SEED     = 32'hFFFF_FFFF,
    parameter logic [31:0] EXPECTED_SIG = 32'h0000_0000,
    localparam int         AW           = $clog2(ROM_DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dev_reset,
    input  logic        busy_in,
    output logic        test_active,
    output logic        int_reset_pulse,
    output logic        ready,
    output logic [31:0] result
);

    seq_state_t    state;
    logic [AW-1:0] rom_addr;
    logic [31:0]   rom_data;
    logic [31:0]   sig;
    logic          misr_load, misr_shift, res_capture, res_clear;

    selftest_ctrl #(
        .TEST_CYCLES (TEST_CYCLES),
        .ROM_DEPTH   (ROM_DEPTH)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_reset   (dev_reset),
        .busy_in     (busy_in),
        .state       (state),
        .rom_addr    (rom_addr),
        .misr_load   (misr_load),
        .misr_shift  (misr_shift),
        .res_capture (res_capture),
        .res_clear   (res_clear)
    );

    selftest_rom #(
        .DEPTH (ROM_DEPTH),
        .SEED  (ROM_SEED)
    ) u_rom (
        .addr (rom_addr),
        .word (rom_data)
    );

    selftest_misr #(
        .POLY (SIG_POLY),
        .INIT (SIG_SEED)
    ) u_misr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (misr_load),
        .shift (misr_shift),
        .din   (rom_data),
        .sig   (sig)
    );

    // Result register: compare outcome on capture, zero on a skipped test.
    always_ff @(posedge clk) begin
        if (!rst_n)           result <= '0;
        else if (res_capture) result <= sig ^ EXPECTED_SIG;
        else if (res_clear)   result <= '0;
    end

    // Phase flags decoded from the controller state.
    assign test_active     = (state == ST_RUN) || (state == ST_CHECK);
    assign int_reset_pulse = (state == ST_PULSE);
    assign ready           = (state == ST_NORM);

endmodule

// File: rtl/selftest_seq_chk.sv
// Module: property checker for selftest_seq, attached with bind.
// Assumes it observes only the top-level ports.
module selftest_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dev_reset,
    input logic        busy_in,
    input logic        test_active,
    input logic        int_reset_pulse,
    input logic        ready,
    input logic [31:0] result
);

    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({test_active, int_reset_pulse, ready}));

    p_start_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_active) |-> (!$past(dev_reset) && !$past(busy_in)));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        int_reset_pulse |=> !int_reset_pulse);

    p_pulse_to_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_reset_pulse && !dev_reset) |=> ready);

    p_reset_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (!test_active && !int_reset_pulse && !ready));

    p_ready_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !dev_reset) |=> ready);

    p_result_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(result));

endmodule

bind selftest_seq selftest_seq_chk u_chk (.*);

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb;

    localparam int          CLK_PERIOD = 10;
    localparam int          N_STEPS    = 40;
    localparam int          DEPTH      = 16;
    localparam logic [31:0] RSEED      = 32'hC3A5_0F1E;
    localparam logic [31:0] POLY       = 32'h04C1_1DB7;
    localparam logic [31:0] SSEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] BAD_DELTA  = 32'h0000_0100;

    // Independent signature model, written from the content formula and the polynomial.
    function automatic logic [31:0] model_word(int a);
        logic [31:0] aa;
        aa = 32'(a);
        return (aa * 32'h9E37_79B1) ^ RSEED;
    endfunction

    function automatic logic [31:0] model_compress(logic [31:0] s, logic [31:0] w);
        logic top;
        top = s[31];
        s = s << 1;
        if (top) s = s ^ POLY;
        return s ^ w;
    endfunction

    function automatic logic [31:0] model_signature();
        logic [31:0] s;
        s = SSEED;
        for (int k = 0; k < N_STEPS; k++) s = model_compress(s, model_word(k % DEPTH));
        return s;
    endfunction

    localparam logic [31:0] GOOD_SIG = model_signature();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_reset = 1'b1;
    logic        busy_in = 1'b0;
    logic        act, pls, rdy, act_b, pls_b, rdy_b;
    logic [31:0] res, res_b;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selftest_seq #(.TEST_CYCLES(N_STEPS), .ROM_DEPTH(DEPTH), .ROM_SEED(RSEED),
                   .SIG_POLY(POLY), .SIG_SEED(SSEED), .EXPECTED_SIG(GOOD_SIG)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .busy_in(busy_in),
        .test_active(act), .int_reset_pulse(pls), .ready(rdy), .result(res));

    selftest_seq #(.TEST_CYCLES(N_STEPS), .ROM_DEPTH(DEPTH), .ROM_SEED(RSEED),
                   .SIG_POLY(POLY), .SIG_SEED(SSEED),
                   .EXPECTED_SIG(GOOD_SIG ^ BAD_DELTA)) u_dut_bad (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .busy_in(busy_in),
        .test_active(act_b), .int_reset_pulse(pls_b), .ready(rdy_b), .result(res_b));

    task automatic check(bit ok, string tag, logic [31:0] actual, logic [31:0] expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, actual, expected, $time);
        end
    endtask

    // Behavioural cycle model: phases 0 idle, 1 stepping, 2 compare, 3 pulse, 4 normal.
    int          m_phase = 0;
    int          m_step = 0;
    bit          m_prev = 1'b1;
    logic [31:0] m_sig = SSEED;
    logic [31:0] m_res = 0;
    logic [31:0] m_res_b = 0;

    always @(posedge clk) begin
        bit fell;
        fell = m_prev && !dev_reset;
        if (!rst_n) begin
            m_phase = 0; m_prev = 1'b1; m_res = 0; m_res_b = 0;
        end else begin
            if (dev_reset) m_phase = 0;
            else if (m_phase == 0) begin
                if (fell && busy_in) begin m_phase = 4; m_res = 0; m_res_b = 0; end
                else if (fell) begin m_phase = 1; m_step = 0; m_sig = SSEED; end
            end else if (m_phase == 1) begin
                m_sig = model_compress(m_sig, model_word(m_step % DEPTH));
                m_step++;
                if (m_step == N_STEPS) m_phase = 2;
            end else if (m_phase == 2) begin
                m_res = m_sig ^ GOOD_SIG;
                m_res_b = m_sig ^ GOOD_SIG ^ BAD_DELTA;
                m_phase = 3;
            end else if (m_phase == 3) m_phase = 4;
            m_prev = dev_reset;
        end
    end

    // Compare both instances against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(act == (m_phase == 1 || m_phase == 2), "R4 test_active vs model", 32'(act), 32'(m_phase == 1 || m_phase == 2));
            check(pls == (m_phase == 3), "R8 pulse vs model", 32'(pls), 32'(m_phase == 3));
            check(rdy == (m_phase == 4), "R3 ready vs model", 32'(rdy), 32'(m_phase == 4));
            check(res === m_res, "R7 result vs model", res, m_res);
            check(res_b === m_res_b, "R6 result (mismatch instance) vs model", res_b, m_res_b);
            check(act_b == act && rdy_b == rdy && pls_b == pls, "R9 instances agree on phase",
                  {29'd0, act_b, pls_b, rdy_b}, {29'd0, act, pls, rdy});
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int n_act;
        int n_pls;
        tick(3);
        check(!act && !pls && !rdy, "R1 flags in reset", {29'd0, act, pls, rdy}, 32'd0);
        check(res == 0, "R1 result in reset", res, 32'd0);
        rst_n = 1'b1;
        tick(3);
        check(!act && !rdy, "R10 no start while device reset high", {30'd0, act, rdy}, 32'd0);

        // Full passing run and a mismatching run side by side.
        dev_reset = 1'b0;
        n_act = 0; n_pls = 0;
        for (int c = 0; c < N_STEPS + 10; c++) begin
            tick(1);
            if (act) n_act++;
            if (pls) n_pls++;
        end
        check(n_act == N_STEPS + 1, "R4 active cycle count", 32'(n_act), 32'(N_STEPS + 1));
        check(n_pls == 1, "R8 single reset pulse", 32'(n_pls), 32'd1);
        check(rdy == 1'b1, "R8 ready after pulse", 32'(rdy), 32'd1);
        check(res == 32'd0, "R5 pass over full ROM gives zero", res, 32'd0);
        check(res_b == BAD_DELTA, "R7 mismatch code", res_b, BAD_DELTA);

        tick(10);
        check(rdy && res_b == BAD_DELTA, "R10 normal operation holds", res_b, BAD_DELTA);

        // Skip path: busy high at the falling edge.
        busy_in = 1'b1; dev_reset = 1'b1;
        tick(2);
        check(!rdy, "R9 re-reset leaves normal operation", 32'(rdy), 32'd0);
        check(res_b == BAD_DELTA, "R9 result kept through reset", res_b, BAD_DELTA);
        dev_reset = 1'b0;
        tick(1);
        check(rdy && !act, "R3 skip goes straight to ready", {30'd0, rdy, act}, 32'd2);
        check(res_b == 32'd0, "R3 skip clears result", res_b, 32'd0);
        busy_in = 1'b0;
        tick(3);

        // Start, then abort mid-run.
        dev_reset = 1'b1; tick(2);
        dev_reset = 1'b0; tick(1);
        check(act == 1'b1, "R2 start after low-busy fall", 32'(act), 32'd1);
        tick(10);
        dev_reset = 1'b1; tick(1);
        check(!act && !rdy, "R9 abort clears active", {30'd0, act, rdy}, 32'd0);
        check(res_b == 32'd0, "R9 abort keeps result", res_b, 32'd0);
        busy_in = 1'b1; tick(3);
        busy_in = 1'b0; tick(1);
        check(!act, "R10 busy toggling under reset starts nothing", 32'(act), 32'd0);

        // Fresh complete run after the abort.
        dev_reset = 1'b0;
        tick(N_STEPS + 8);
        check(rdy && res == 0, "R6 rerun passes", res, 32'd0);
        check(res_b == BAD_DELTA, "R7 rerun mismatch code", res_b, BAD_DELTA);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        finished = 1'b1;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule